// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Compare Reset

This block is a free-running 16-bit up-counter clocked through a power-of-two prescaler. A host reaches the count through an 8-bit port with one address for the low byte and one for the high byte. In buffered access mode the high byte travels through two shadow registers. Reading the low byte freezes the high byte for a later read. A high-byte write waits in a buffer until the low byte is written, so both halves load in the same cycle. In direct access mode the high byte is read and written in place.

A comparator watches the count against a 16-bit compare value. When the compare mode input carries the special-event code, a match clears the counter and the prescaler, and a one-cycle event pulse is produced. This gives a periodic trigger with an exact period. Wrapping from the all-ones count to zero raises a sticky overflow flag, which the host clears with a strobe.

Top module: `cmp_timer16`

## Requirements
- R1: After reset the count, the prescaler, both high-byte buffers, the overflow flag and the event output are all zero.
- R2: While `en_i` is high the count rises by one every 1, 2, 4 or 8 clocks for `psc_sel_i` = 0, 1, 2 or 3. While `en_i` is low the count and the prescaler hold.
- R3: In buffered mode (`acc16_i`=1), a read strobe at `addr_i`=0 returns the live low byte and latches the live high byte. A later read at `addr_i`=1 returns that latched byte.
- R4: In buffered mode a write at `addr_i`=1 changes only the write buffer. It leaves the count and the prescaler phase untouched. A write at `addr_i`=0 loads {write buffer, data} into the count in one cycle.
- R5: Every low-byte write clears the prescaler, so the first increment after it comes exactly one prescale period later.
- R6: In direct mode (`acc16_i`=0) `addr_i`=1 reads the live high byte, and a write there replaces the count's high byte at once. A low-byte write keeps the current high byte.
- R7: With `cmp_mode_i` = 4'b1011, a count equal to `cmp_val_i` is replaced by zero on the next clock and the prescaler is cleared. This applies whether `en_i` is high or low. Any other code never resets the count.
- R8: Each compare reset raises `evt_o` for exactly the one clock in which the count reads zero after that reset.
- R9: An increment from FFFFh to 0000h sets `ovf_o`. The flag stays set until `ovf_clr_i` is high at a clock edge without a new overflow in that same edge; a new overflow wins.
- R10: Count updates are ranked: low-byte write, then direct high-byte write, then compare reset, then increment. A compare reset suppressed by a write produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| psc_sel_i | input | 2 | Prescale select, ratio 2^value |
| acc16_i | input | 1 | 1 = buffered high byte, 0 = direct |
| cmp_mode_i | input | 4 | Compare mode; 4'b1011 enables compare reset |
| cmp_val_i | input | 16 | Compare value |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (latches high byte on low read) |
| addr_i | input | 1 | 0 = low byte, 1 = high byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| evt_o | output | 1 | One-clock compare event |

## Verification
The bench measures the increment spacing right after a low-byte write. A prescaler left uncleared by the write would show a short first period. It checks that a buffered high-byte write leaves the visible count unchanged. A design that loaded the high byte early would tear the 16-bit value. It drives a low-byte write into the very cycle of a compare match. A wrong priority would show zero and a stray event instead of the written value. A random phase compares every output on every clock with a behavioural model, across mode, ratio and compare changes and across wraps through FFFFh, where a missed or duplicated overflow would surface.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] CMP_SPECIAL = 4'b1011;
  typedef enum logic {ACC_DIRECT = 1'b0, ACC_BUFFERED = 1'b1} acc_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int PSC_W = (1 << SEL_W) - 1;

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] lim;

  assign lim    = PSC_W'((1 << sel_i) - 1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else if (en_i)           cnt_q <= cnt_q + 1'b1;
  end

  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  a_r5_clear_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [3:0]       mode_i,
  output logic             match_o
);
  import tmr_pkg::*;
  assign match_o = (mode_i == CMP_SPECIAL) && (cnt_i == cmp_i);
endmodule

// File: rtl/tmr_access.sv
module tmr_access #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc16_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             wr_lo_o,
  output logic             wr_hi_dir_o,
  output logic [CNT_W-BUS_W-1:0] hi_load_o,
  output logic [BUS_W-1:0] rdata_o
);
  import tmr_pkg::*;
  localparam int HI_W = CNT_W - BUS_W;

  logic [HI_W-1:0] hi_wr_q, hi_rd_q;
  logic            buffered;
  logic [HI_W-1:0] cnt_hi;

  assign buffered    = (acc_mode_e'(acc16_i) == ACC_BUFFERED);
  assign cnt_hi      = cnt_i[CNT_W-1:BUS_W];
  assign wr_lo_o     = wr_en_i && !addr_i;
  assign wr_hi_dir_o = wr_en_i && addr_i && !buffered;
  assign hi_load_o   = buffered ? hi_wr_q : cnt_hi;

  always_comb begin
    if (!addr_i)       rdata_o = cnt_i[BUS_W-1:0];
    else if (buffered) rdata_o = BUS_W'(hi_rd_q);
    else               rdata_o = BUS_W'(cnt_hi);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_wr_q <= '0;
      hi_rd_q <= '0;
    end else begin
      if (wr_en_i && addr_i && buffered)  hi_wr_q <= HI_W'(wdata_i);
      if (rd_en_i && !addr_i && buffered) hi_rd_q <= cnt_hi;
    end
  end

  a_r3_latch_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_i && acc16_i) |=> (hi_rd_q == $past(cnt_i[CNT_W-1:BUS_W])));
  a_r4_buffer_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && acc16_i) |=> (hi_wr_q == $past(HI_W'(wdata_i))));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-BUS_W-1:0] hi_load_i,
  input  logic             match_i,
  input  logic             ovf_clr_i,
  output logic             cmp_rst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             ovf_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q;
  logic             evt_q, ovf_q, ovf_set;

  assign cmp_rst_o = match_i && !wr_lo_i && !wr_hi_i;
  assign ovf_set   = tick_i && !wr_lo_i && !wr_hi_i && !match_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_lo_i)        cnt_q <= {hi_load_i, wdata_i};
      else if (wr_hi_i)   cnt_q <= {HI_W'(wdata_i), cnt_q[BUS_W-1:0]};
      else if (match_i)   cnt_q <= '0;
      else if (tick_i)    cnt_q <= cnt_q + 1'b1;
      evt_q <= cmp_rst_o;
      if (ovf_set)        ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
  assign ovf_o = ovf_q;

  a_r7_reset_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_rst_o |=> (cnt_q == '0));
  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_lo_i && !wr_hi_i && !match_i) |=> $stable(cnt_q));
  a_r9_ovf_from_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> ($past(cnt_q) == {CNT_W{1'b1}}));
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16 #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             acc16_i,
  input  logic [3:0]       cmp_mode_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             ovf_clr_i,
  output logic             ovf_o,
  output logic             evt_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_w;
  logic [HI_W-1:0]  hi_load_w;
  logic tick_w, match_w, cmp_rst_w, wr_lo_w, wr_hi_w;

  tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sel_i(psc_sel_i),
    .clr_i(wr_lo_w || cmp_rst_w), .tick_o(tick_w));

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i(cnt_w), .cmp_i(cmp_val_i), .mode_i(cmp_mode_i), .match_o(match_w));

  tmr_access #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc16_i(acc16_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt_w),
    .wr_lo_o(wr_lo_w), .wr_hi_dir_o(wr_hi_w), .hi_load_o(hi_load_w),
    .rdata_o(rdata_o));

  tmr_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .wr_lo_i(wr_lo_w),
    .wr_hi_i(wr_hi_w), .wdata_i(wdata_i), .hi_load_i(hi_load_w),
    .match_i(match_w), .ovf_clr_i(ovf_clr_i), .cmp_rst_o(cmp_rst_w),
    .cnt_o(cnt_w), .evt_o(evt_o), .ovf_o(ovf_o));

  a_r8_event_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (cnt_w == '0));
endmodule

// File: tb/cmp_timer16_tb_top.sv
`timescale 1ns/1ps
module cmp_timer16_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, acc16 = 0, wr_en = 0, rd_en = 0, addr = 0, ovf_clr = 0;
  logic [1:0] psc_sel = 0;
  logic [3:0] cmp_mode = 0;
  logic [15:0] cmp_val = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ovf, evt;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .psc_sel_i(psc_sel),
    .acc16_i(acc16), .cmp_mode_i(cmp_mode), .cmp_val_i(cmp_val),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ovf_clr_i(ovf_clr), .ovf_o(ovf), .evt_o(evt));

  // behavioural reference
  int m_cnt, m_psc, m_hw, m_hr, m_ovf, m_evt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_psc = 0; m_hw = 0; m_hr = 0; m_ovf = 0; m_evt = 0;
    end else begin
      int ratio, nxt;
      bit wl, wh8, match, tick, mrst;
      ratio = 1 << psc_sel;
      wl    = wr_en && !addr;
      wh8   = wr_en && addr && !acc16;
      match = (cmp_mode == 4'b1011) && (m_cnt == int'(cmp_val));
      tick  = en && (m_psc == ratio - 1);
      mrst  = match && !wl && !wh8;
      if (wl) nxt = ((acc16 ? m_hw : (m_cnt >> 8)) << 8) | wdata;
      else if (wh8) nxt = (wdata << 8) | (m_cnt & 255);
      else if (match) nxt = 0;
      else if (tick) nxt = (m_cnt + 1) & 16'hFFFF;
      else nxt = m_cnt;
      if (!wl && !wh8 && !match && tick && m_cnt == 16'hFFFF) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_evt = mrst;
      if (wl || mrst || tick) m_psc = 0;
      else if (en) m_psc = (m_psc + 1) & 7;
      if (wr_en && addr && acc16) m_hw = wdata;
      if (rd_en && !addr && acc16) m_hr = m_cnt >> 8;
      m_cnt = nxt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      int er;
      er = addr ? (acc16 ? m_hr : (m_cnt >> 8)) : (m_cnt & 255);
      chk("R2 model rdata", rdata, er);
      chk("R8 model evt", evt, m_evt);
      chk("R9 model ovf", ovf, m_ovf);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr(input bit a, input logic [7:0] d);
    cyc(); wr_en = 1; addr = a; wdata = d;
    cyc(); wr_en = 0; addr = 0;
  endtask
  task automatic sample(); #1; endtask

  int k, pulses, gap;
  bit prev;
  initial begin
    repeat (3) cyc();
    sample();
    chk("R1 reset low", rdata, 0);
    chk("R1 reset evt", evt, 0);
    chk("R1 reset ovf", ovf, 0);
    rst_n = 1;
    cyc(); addr = 1; sample();
    chk("R1 reset high", rdata, 0);
    addr = 0;

    // buffered access
    acc16 = 1;
    wr(1, 8'h12); sample();
    chk("R4 high write held back", rdata, 0);
    addr = 1; sample();
    chk("R4 count high untouched", rdata, 0);
    addr = 0;
    wr(0, 8'h34); sample();
    chk("R4 low write loads", rdata, 8'h34);
    cyc(); rd_en = 1; addr = 0;
    cyc(); rd_en = 0; addr = 1; sample();
    chk("R3 latched high", rdata, 8'h12);

    // direct access
    acc16 = 0;
    wr(1, 8'h56); addr = 1; sample();
    chk("R6 direct high", rdata, 8'h56);
    addr = 0;

    // prescaler spacing right after a low write
    wr(1, 8'h00);
    for (int s = 0; s < 4; s++) begin
      psc_sel = 2'(s); en = 1;
      wr(0, 8'h00); sample();
      k = 0;
      while (rdata == 0 && k < 40) begin cyc(); sample(); k++; end
      chk($sformatf("R5 first period sel%0d", s), k, 1 << s);
      k = 0;
      while (rdata == 1 && k < 40) begin cyc(); sample(); k++; end
      chk($sformatf("R2 period sel%0d", s), k, 1 << s);
    end
    en = 0;
    cyc(); sample(); k = rdata;
    repeat (10) cyc(); sample();
    chk("R2 hold when disabled", rdata, k);

    // compare reset
    psc_sel = 0; en = 1; cmp_val = 16'd3; cmp_mode = 4'b1011;
    wr(0, 8'h00);
    pulses = 0; prev = 0; gap = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(); sample();
      if (evt) pulses++;
      if (evt && prev) gap++;
      prev = evt;
      if (rdata > 3) gap++;
    end
    chk("R7 compare resets periodically", pulses, 10);
    chk("R8 single-cycle pulse, count bounded", gap, 0);
    cmp_mode = 4'b1010;
    wr(0, 8'h00);
    repeat (8) cyc(); sample();
    chk("R7 other code no reset", rdata > 3, 1);
    chk("R7 other code no event", evt, 0);

    // priority: low write on the match cycle
    en = 0; cmp_mode = 4'b1011; cmp_val = 16'h0010;
    wr(1, 8'h00);
    cyc(); wr_en = 1; addr = 0; wdata = 8'h10;
    cyc(); wdata = 8'h77;
    cyc(); wr_en = 0; sample();
    chk("R10 write beats compare", rdata, 8'h77);
    chk("R10 no event on suppressed reset", evt, 0);
    wr(0, 8'h10);
    cyc(); sample();
    chk("R7 reset while disabled", rdata, 0);
    cmp_mode = 0;

    // overflow
    wr(1, 8'hFF); wr(0, 8'hFF);
    en = 1; psc_sel = 0;
    repeat (3) cyc(); sample();
    chk("R9 overflow set", ovf, 1);
    ovf_clr = 1; cyc(); ovf_clr = 0; sample();
    chk("R9 overflow cleared", ovf, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      cyc();
      r = $urandom % 100;
      wr_en = (r < 8);
      rd_en = (r >= 8 && r < 35);
      addr = $urandom % 2;
      wdata = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      en = ($urandom % 10) != 0;
      ovf_clr = ($urandom % 60) == 0;
      if (i % 450 == 0) acc16 = $urandom % 2;
      if (i % 170 == 0) psc_sel = 2'($urandom);
      if (i % 230 == 0) begin
        cmp_mode = ($urandom % 4 == 0) ? 4'b0010 : 4'b1011;
        cmp_val = ($urandom % 2) ? 16'($urandom % 64) : 16'hFF00 | 16'($urandom % 256);
      end
    end
    cyc(); wr_en = 0; rd_en = 0; ovf_clr = 0;
    repeat (2) cyc();
    finish_run();
  end
endmodule